// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the shared timing reference for a two-output pulse-width modulator. A two-stage prescaler turns the system clock into a slower count tick. A 16-bit counter advances on that tick. It can count up, count down, count up then down, or hold still. The counter compares itself against an active period value. It reports a zero-match event, a period-match event and the current counting direction. Compare and output-action logic use these outputs downstream.

The period value is written through a one-cycle write strobe. A load-path select chooses between two paths. The write can update the active period at once, or it can go into a shadow copy that the counter takes up at its next zero match. A run-mode field sets how the counter responds to a halt request. It can freeze at once, finish the current cycle and park at zero, or ignore the request. Reset is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is asserted, and after it, the counter reads 0 and the direction flag reads 1 (upward).
- R2: The counter advances once every F*C clock cycles. F is 1 for a fine code of 0 and twice the fine code otherwise. C is 2 raised to the coarse code.
- R3: Mode 2'b00 counts upward. When the counter is at or above the active period it returns to 0. The direction flag is 1.
- R4: Mode 2'b01 counts downward. From 0 it reloads the active period. The direction flag is 0.
- R5: Mode 2'b10 counts up to the active period, then down to 0, then up again. The direction flag is 1 on the way up, including at the period value, and 0 on the way down, including at 0.
- R6: Mode 2'b11 holds the counter value and raises no event.
- R7: The zero-match event is high when the counter sits at 0, and the period-match event is high when the counter equals the active period. Each is high only in a clock cycle where the counter advances, so each lasts one clock per prescaled tick.
- R8: With the load-path select at 0, a write goes only to the shadow copy. The active period keeps its old value until the next zero-match event, where it takes the shadow value.
- R9: With the load-path select at 1, a write sets the active period at the next clock edge. It also sets the shadow copy.
- R10: Run mode 2'b00 with the halt request high stops the counter at the next edge. The counter holds for as long as the request stays high.
- R11: Run mode 2'b01 with the halt request high lets the counter keep advancing until it reads 0. It then parks there until the request falls.
- R12: Run modes 2'b10 and 2'b11 ignore the halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_mode_i | input | 2 | Counting mode: up, down, up-down or hold |
| fine_code_i | input | 3 | Fine prescaler code (ratio 1 or twice the code) |
| coarse_code_i | input | 3 | Coarse prescaler code (ratio 2 to the code) |
| run_mode_i | input | 2 | Response to a halt request |
| halt_req_i | input | 1 | Halt request |
| prd_direct_i | input | 1 | Period load path: 1 direct, 0 through shadow |
| prd_wr_i | input | 1 | One-cycle period write strobe |
| prd_wdata_i | input | 16 | Period write value |
| cnt_o | output | 16 | Current counter value |
| cnt_up_o | output | 1 | Direction flag, 1 when counting upward |
| zero_evt_o | output | 1 | Zero-match event |
| prd_evt_o | output | 1 | Period-match event |

## Verification
The assertions assume that every control input is synchronous to the clock and has settled before the rising edge. They also assume that a period write is a single-cycle strobe whose data is valid with it. The checks on halting and on hold mode compare the counter one edge later, so they rely on the mode and run fields not changing in the same cycle that they judge. The bench drives all inputs on the falling edge and samples just before it drives. It lets the prescaler finish at least one full interval after any code change before it takes a measurement.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cnt_mode_e;

  localparam logic [1:0] RUN_HALT_NOW   = 2'b00;
  localparam logic [1:0] RUN_HALT_CYCLE = 2'b01;

endpackage

// File: rtl/ptb_rst_sync.sv
module ptb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] fine_code_i,
  input  logic [CODE_W-1:0] coarse_code_i,
  output logic              tick_o
);

  localparam int FINE_MAX  = 2 * ((1 << CODE_W) - 1);
  localparam int RATIO_MAX = FINE_MAX << ((1 << CODE_W) - 1);
  localparam int RATIO_W   = $clog2(RATIO_MAX + 1);

  logic [CODE_W:0]    fine_ratio;
  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] ratio_m1;
  logic [RATIO_W-1:0] ps_q;
  logic [RATIO_W-1:0] ps_d;
  logic               wrap;

  // fine stage: 1 for code 0, otherwise twice the code
  always_comb begin
    if (fine_code_i == '0) begin
      fine_ratio = (CODE_W+1)'(1);
    end else begin
      fine_ratio = {fine_code_i, 1'b0};
    end
  end

  // coarse stage multiplies by 2**code: a shift, no multiplier
  assign ratio    = RATIO_W'(fine_ratio) << coarse_code_i;
  assign ratio_m1 = ratio - RATIO_W'(1);
  assign wrap     = (ps_q >= ratio_m1);

  always_comb begin
    if (wrap) begin
      ps_d = '0;
    end else begin
      ps_d = ps_q + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q <= '0;
    end else begin
      ps_q <= ps_d;
    end
  end

  assign tick_o = wrap;

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && (ratio > RATIO_W'(1))) |=> (!tick_o || !$stable(ratio))); // R2

endmodule

// File: rtl/ptb_period.sv
module ptb_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             direct_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_i,
  output logic [CNT_W-1:0] active_o
);

  logic [CNT_W-1:0] shadow_q;
  logic [CNT_W-1:0] shadow_d;
  logic [CNT_W-1:0] active_q;
  logic [CNT_W-1:0] active_d;
  logic             upd_en;

  assign upd_en = wr_i | load_i;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    if (load_i) begin
      active_d = shadow_q;
    end
    if (wr_i) begin
      shadow_d = wdata_i;
      if (direct_i) begin
        active_d = wdata_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else if (upd_en) begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && direct_i) |=> (active_o == $past(wdata_i))); // R9

  AST_SHADOW_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !direct_i && !load_i) |=> $stable(active_o)); // R8

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
  import ptb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       run_mode_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             zero_evt_o,
  output logic             prd_evt_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_mode_e        mode;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             up_q;
  logic             up_d;
  logic             halt_block;
  logic             adv;
  logic             at_zero;
  logic             at_prd;

  assign mode    = cnt_mode_e'(mode_i);
  assign at_zero = (cnt_q == '0);
  assign at_prd  = (cnt_q == prd_i);

  // halt gating by run mode; other run codes let the counter run
  always_comb begin
    halt_block = 1'b0;
    if (halt_i) begin
      if (run_mode_i == RUN_HALT_NOW) begin
        halt_block = 1'b1;
      end else if ((run_mode_i == RUN_HALT_CYCLE) && at_zero) begin
        halt_block = 1'b1;
      end
    end
  end

  assign adv = tick_i && (mode != CM_HOLD) && !halt_block;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    unique case (mode)
      CM_UP: begin
        up_d = 1'b1;
        if (cnt_q >= prd_i) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      CM_DOWN: begin
        up_d = 1'b0;
        if (at_zero) begin
          cnt_d = prd_i;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      CM_UPDN: begin
        if (up_q) begin
          if (cnt_q >= prd_i) begin
            up_d  = 1'b0;
            cnt_d = at_zero ? '0 : (cnt_q - ONE);
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else begin
          if (at_zero) begin
            up_d  = 1'b1;
            cnt_d = (prd_i == '0) ? '0 : ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end
      default: begin
        cnt_d = cnt_q;
        up_d  = up_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (adv) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign up_o       = up_q;
  assign zero_evt_o = adv && at_zero;
  assign prd_evt_o  = adv && at_prd;

  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |=> $stable(cnt_o)); // R6

  AST_HALT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && (run_mode_i == 2'b00)) |=> $stable(cnt_o)); // R10

  AST_CYCLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && (run_mode_i == 2'b01) && (cnt_o == '0)) |=> (cnt_o == '0)); // R11

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !halt_i && (mode_i == 2'b00) && (cnt_o >= prd_i)) |=> (cnt_o == '0)); // R3

  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !halt_i && (mode_i == 2'b01) && (cnt_o == '0)) |=> (cnt_o == $past(prd_i))); // R4

  AST_UPDN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !halt_i && (mode_i == 2'b10) && up_o && (cnt_o >= prd_i)) |=> !up_o); // R5

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctr_mode_i,
  input  logic [CODE_W-1:0] fine_code_i,
  input  logic [CODE_W-1:0] coarse_code_i,
  input  logic [1:0]        run_mode_i,
  input  logic              halt_req_i,
  input  logic              prd_direct_i,
  input  logic              prd_wr_i,
  input  logic [CNT_W-1:0]  prd_wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_up_o,
  output logic              zero_evt_o,
  output logic              prd_evt_o
);

  logic             rst_n_s;
  logic             tick;
  logic [CNT_W-1:0] prd_active;
  logic             zero_evt;

  ptb_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  ptb_prescaler #(
    .CODE_W(CODE_W)
  ) u_prescaler (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .fine_code_i   (fine_code_i),
    .coarse_code_i (coarse_code_i),
    .tick_o        (tick)
  );

  ptb_period #(
    .CNT_W(CNT_W)
  ) u_period (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_i     (prd_wr_i),
    .direct_i (prd_direct_i),
    .wdata_i  (prd_wdata_i),
    .load_i   (zero_evt),
    .active_o (prd_active)
  );

  ptb_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick_i     (tick),
    .mode_i     (ctr_mode_i),
    .run_mode_i (run_mode_i),
    .halt_i     (halt_req_i),
    .prd_i      (prd_active),
    .cnt_o      (cnt_o),
    .up_o       (cnt_up_o),
    .zero_evt_o (zero_evt),
    .prd_evt_o  (prd_evt_o)
  );

  assign zero_evt_o = zero_evt;

  AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n_s)
    (zero_evt_o || prd_evt_o) |-> tick); // R7

endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;

  logic        clk;
  logic        rst_n;
  logic [1:0]  ctr_mode;
  logic [2:0]  fine_code;
  logic [2:0]  coarse_code;
  logic [1:0]  run_mode;
  logic        halt_req;
  logic        prd_direct;
  logic        prd_wr;
  logic [15:0] prd_wdata;
  logic [15:0] cnt;
  logic        cnt_up;
  logic        zero_evt;
  logic        prd_evt;

  int n_chk = 0;
  int n_err = 0;

  pwm_timebase i_pwm_timebase (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctr_mode_i    (ctr_mode),
    .fine_code_i   (fine_code),
    .coarse_code_i (coarse_code),
    .run_mode_i    (run_mode),
    .halt_req_i    (halt_req),
    .prd_direct_i  (prd_direct),
    .prd_wr_i      (prd_wr),
    .prd_wdata_i   (prd_wdata),
    .cnt_o         (cnt),
    .cnt_up_o      (cnt_up),
    .zero_evt_o    (zero_evt),
    .prd_evt_o     (prd_evt)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_prd(input int val, input bit direct);
    @(negedge clk);
    prd_wr     = 1'b1;
    prd_direct = direct;
    prd_wdata  = 16'(val);
    @(negedge clk);
    prd_wr     = 1'b0;
  endtask

  task automatic wait_cnt(input int val);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (cnt != 16'(val) && guard < 5000);
  endtask

  task automatic wait_change();
    logic [15:0] v;
    int guard = 0;
    v = cnt;
    do begin
      @(negedge clk);
      guard++;
    end while (cnt == v && guard < 5000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cnt == 16'd0, "R1 cnt in reset", cnt, 0);
    chk(cnt_up == 1'b1, "R1 dir in reset", cnt_up, 1);
  endtask

  task automatic t_up();
    ctr_mode = 2'b00;
    write_prd(5, 1'b1);
    wait_cnt(0);
    for (int i = 0; i < 12; i++) begin
      int e = i % 6;
      chk(cnt == 16'(e), "R3 up count", cnt, e);
      chk(cnt_up == 1'b1, "R3 up dir", cnt_up, 1);
      chk(zero_evt == (e == 0), "R7 zero evt up", zero_evt, int'(e == 0));
      chk(prd_evt == (e == 5), "R7 prd evt up", prd_evt, int'(e == 5));
      @(negedge clk);
    end
  endtask

  task automatic t_down();
    ctr_mode = 2'b01;
    wait_cnt(5);
    for (int i = 0; i < 12; i++) begin
      int e = 5 - (i % 6);
      chk(cnt == 16'(e), "R4 down count", cnt, e);
      chk(cnt_up == 1'b0, "R4 down dir", cnt_up, 0);
      chk(zero_evt == (e == 0), "R7 zero evt down", zero_evt, int'(e == 0));
      chk(prd_evt == (e == 5), "R7 prd evt down", prd_evt, int'(e == 5));
      @(negedge clk);
    end
  endtask

  task automatic t_updn();
    int seq_c[6] = '{0, 1, 2, 3, 2, 1};
    int seq_d[6] = '{0, 1, 1, 1, 0, 0};
    write_prd(3, 1'b1);
    ctr_mode = 2'b10;
    wait_cnt(0);
    wait_cnt(0);
    for (int i = 0; i < 12; i++) begin
      int k = i % 6;
      chk(cnt == 16'(seq_c[k]), "R5 updn count", cnt, seq_c[k]);
      chk(cnt_up == seq_d[k][0], "R5 updn dir", cnt_up, seq_d[k]);
      chk(prd_evt == (seq_c[k] == 3), "R5 updn prd evt", prd_evt, int'(seq_c[k] == 3));
      chk(zero_evt == (seq_c[k] == 0), "R5 updn zero evt", zero_evt, int'(seq_c[k] == 0));
      @(negedge clk);
    end
  endtask

  task automatic t_freeze();
    logic [15:0] c;
    ctr_mode = 2'b11;
    @(negedge clk);
    c = cnt;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(cnt == c, "R6 hold value", cnt, c);
      chk(!zero_evt && !prd_evt, "R6 hold no event", {zero_evt, prd_evt}, 0);
    end
  endtask

  task automatic t_events();
    int nz = 0;
    int np = 0;
    bit pz = 1'b0;
    bit pp = 1'b0;
    ctr_mode  = 2'b00;
    write_prd(2, 1'b1);
    fine_code = 3'd2;
    wait_cnt(1);
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      if (zero_evt) nz++;
      if (prd_evt) np++;
      chk(!(pz && zero_evt) && !(pp && prd_evt), "R7 event one clock", {zero_evt, prd_evt}, 0);
      pz = zero_evt;
      pp = prd_evt;
    end
    chk(nz == 4, "R7 zero evt count", nz, 4);
    chk(np == 4, "R7 prd evt count", np, 4);
    fine_code = 3'd0;
  endtask

  task automatic measure(input int f, input int c, input int exp);
    int n = 0;
    logic [15:0] v;
    fine_code   = 3'(f);
    coarse_code = 3'(c);
    wait_change();
    wait_change();
    v = cnt;
    while (cnt == v && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp, "R2 tick interval", n, exp);
  endtask

  task automatic t_prescale();
    ctr_mode = 2'b00;
    write_prd(16'hFFFF, 1'b1);
    measure(0, 0, 1);
    measure(2, 1, 8);
    measure(3, 2, 24);
    measure(0, 3, 8);
    measure(1, 0, 2);
    measure(7, 7, 1792);
    fine_code   = 3'd0;
    coarse_code = 3'd0;
  endtask

  task automatic t_shadow();
    int exp_seq[8] = '{3, 4, 5, 0, 1, 2, 0, 1};
    write_prd(5, 1'b1);
    wait_cnt(0);
    @(negedge clk);
    prd_wr     = 1'b1;
    prd_direct = 1'b0;
    prd_wdata  = 16'd2;
    @(negedge clk);
    prd_wr     = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(cnt == 16'(exp_seq[i]), "R8 shadow load", cnt, exp_seq[i]);
      if (i == 2) chk(prd_evt == 1'b1, "R8 old period in force", prd_evt, 1);
    end
  endtask

  task automatic t_direct();
    wait_cnt(0);
    @(negedge clk);
    prd_wr     = 1'b1;
    prd_direct = 1'b1;
    prd_wdata  = 16'd7;
    @(negedge clk);
    prd_wr     = 1'b0;
    chk(cnt == 16'd2, "R9 direct before", cnt, 2);
    for (int i = 3; i <= 8; i++) begin
      int e = i % 8;
      @(negedge clk);
      chk(cnt == 16'(e), "R9 direct period", cnt, e);
    end
  endtask

  task automatic t_halt_now();
    run_mode = 2'b00;
    wait_cnt(3);
    halt_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(cnt == 16'd3, "R10 halt now", cnt, 3);
      chk(!zero_evt && !prd_evt, "R10 no event halted", {zero_evt, prd_evt}, 0);
    end
    halt_req = 1'b0;
    @(negedge clk);
    chk(cnt == 16'd4, "R10 resume", cnt, 4);
  endtask

  task automatic t_halt_cycle();
    int exp_seq[8] = '{4, 5, 6, 7, 0, 0, 0, 0};
    run_mode = 2'b01;
    wait_cnt(3);
    halt_req = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(cnt == 16'(exp_seq[i]), "R11 halt at cycle end", cnt, exp_seq[i]);
    end
    halt_req = 1'b0;
    @(negedge clk);
    chk(cnt == 16'd1, "R11 resume", cnt, 1);
  endtask

  task automatic t_free(input logic [1:0] rm);
    run_mode = rm;
    wait_cnt(2);
    halt_req = 1'b1;
    for (int i = 3; i <= 9; i++) begin
      int e = i % 8;
      @(negedge clk);
      chk(cnt == 16'(e), "R12 halt ignored", cnt, e);
    end
    halt_req = 1'b0;
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    #1ns;
    chk(cnt == 16'd0, "R1 async clear", cnt, 0);
    chk(cnt_up == 1'b1, "R1 dir after clear", cnt_up, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    ctr_mode    = 2'b00;
    fine_code   = 3'd0;
    coarse_code = 3'd0;
    run_mode    = 2'b11;
    halt_req    = 1'b0;
    prd_direct  = 1'b1;
    prd_wr      = 1'b0;
    prd_wdata   = 16'd0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_up();
    t_down();
    t_updn();
    t_freeze();
    t_events();
    t_prescale();
    t_shadow();
    t_direct();
    t_halt_now();
    t_halt_cycle();
    t_free(2'b11);
    t_free(2'b10);
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule